// File: doc/BRIEF.md
# Multi-Polynomial Parallel CRC Channel

This block is the datapath of a single CRC channel. On each input write it takes one whole data word, as wide as the degree of the active polynomial, and folds it into the CRC register in one clock cycle. Each word passes through a one-cycle parallel XOR network. A registered configuration selects one of four fixed kernels: a 32-bit Ethernet CRC, a 32-bit safety CRC, a 16-bit CCITT CRC and an 8-bit SAE CRC. Four separate switches give per-byte input bit reflection, byte swapping, reflection of the result and an all-ones final XOR.

Software-style use follows a fixed order. A configuration write selects the kernel and the switches, and it also seeds the CRC register. A seed strobe restarts a message under the same configuration. The data words then follow, and the post-processed result is read two cycles after the last write. The raw CRC register is visible as well. For the narrower kernels, both outputs are zero-extended to 32 bits.

Top module: `crc_lane`

## Requirements
- R1: `cfg_kern` encoding: 0 is the 32-bit polynomial 0x04C11DB7, 1 is the 32-bit polynomial 0xF4ACFB13, 2 is the 16-bit polynomial 0x1021 and 3 is the 8-bit polynomial 0x1D. Each is computed MSB-first, with the word's most significant bit entering first.
- R2: Each `din_valid` consumes one word of the kernel width in a single update. For kernels 2 and 3, `din` bits above that width are ignored.
- R3: When input reflection is set, the bit order inside every byte of the word is reversed before the update.
- R4: When byte swap is set and the width is 32, the four bytes are reversed. When it is set and the width is 16, the two low bytes are exchanged. For the 8-bit kernel, byte swap has no effect.
- R5: When output reflection is set, the CRC value is bit-reversed across the kernel width to form the result.
- R6: When final XOR is set, the result is XORed with an all-ones mask of the kernel width. This XOR is applied after output reflection.
- R7: `crc_out` changes on the first rising edge after a write. `res_out` reflects that new value one edge later.
- R8: After reset the kernel is 0, input reflection, output reflection and final XOR are on, byte swap is off, `crc_out` is 0xFFFFFFFF and `res_out` is 0.
- R9: `cfg_wr` loads the kernel and the switches, and it seeds `crc_out` with an all-ones value of the new width. When `cfg_std` is set, the switch inputs are ignored and standard values are used instead. For kernels 0 and 1 these are reflect-in on, reflect-out on and XOR on. For kernel 2 all three are off. For kernel 3 only XOR is on. Byte swap is off in every case.
- R10: `init_load` reseeds `crc_out` with all ones of the current width. Priority is `cfg_wr` over `init_load`, and `init_load` over `din_valid`.
- R11: For widths below 32, the upper bits of `crc_out` and `res_out` are zero.
- R12: With no strobe asserted, `crc_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration load and reseed |
| cfg_std | input | 1 | Use the standard switch values for the kernel |
| cfg_kern | input | 2 | Kernel select |
| cfg_refl_in | input | 1 | Per-byte input reflection |
| cfg_refl_out | input | 1 | Result reflection |
| cfg_xor | input | 1 | All-ones final XOR |
| cfg_swap | input | 1 | Input byte swap |
| init_load | input | 1 | Reseed the CRC register |
| din_valid | input | 1 | Input word write |
| din | input | 32 | Input word |
| crc_out | output | 32 | Raw CRC register |
| res_out | output | 32 | Post-processed result |

## Verification
The hardest condition to reach from the ports is the pipeline overlap. Here the result stage is still post-processing the previous CRC value while a new word is already updating the register. Hitting it needs back-to-back writes, so the stimulus issues consecutive writes and samples both outputs in the cycle between them. Strobe collisions are forced directly, with a configuration load, a seed and a data write in the same cycle. A known 8-bit check value on the digits "123456789" anchors the model, and random configurations with random word streams cover the switch combinations.

// File: rtl/crc_lane.sv
module crc_lane #(
  parameter logic [31:0] POLY_K0 = 32'h04C11DB7,
  parameter logic [31:0] POLY_K1 = 32'hF4ACFB13,
  parameter logic [31:0] POLY_K2 = 32'h00001021,
  parameter logic [31:0] POLY_K3 = 32'h0000001D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_std,
  input  logic [1:0]  cfg_kern,
  input  logic        cfg_refl_in,
  input  logic        cfg_refl_out,
  input  logic        cfg_xor,
  input  logic        cfg_swap,
  input  logic        init_load,
  input  logic        din_valid,
  input  logic [31:0] din,
  output logic [31:0] crc_out,
  output logic [31:0] res_out
);

  logic [1:0]  kern_q;
  logic        ri_q, ro_q, xo_q, sw_q;
  logic [31:0] crc_q, res_q, word, nxt, post;

  function automatic int kw(input logic [1:0] k);
    return (k == 2'd3) ? 8 : (k == 2'd2) ? 16 : 32;
  endfunction

  function automatic logic [31:0] kmask(input logic [1:0] k);
    return (k == 2'd3) ? 32'hFF : (k == 2'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] kpoly(input logic [1:0] k);
    case (k)
      2'd0:    return POLY_K0;
      2'd1:    return POLY_K1;
      2'd2:    return POLY_K2;
      default: return POLY_K3;
    endcase
  endfunction

  function automatic logic [31:0] byte_refl(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[(i & ~7) | (7 - (i & 7))];
    return r;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31 - i];
    return r;
  endfunction

  function automatic logic [31:0] step(input logic [31:0] c, input logic [31:0] d,
                                       input logic [1:0] k);
    int          sh;
    logic [31:0] a, p;
    sh = 32 - kw(k);
    a  = (c ^ d) << sh;
    p  = kpoly(k) << sh;
    for (int i = 0; i < 32; i++)
      if (i < kw(k)) a = a[31] ? ((a << 1) ^ p) : (a << 1);
    return a >> sh;
  endfunction

  always_comb begin
    word = din & kmask(kern_q);
    if (ri_q) word = byte_refl(word);
    if (sw_q && kern_q != 2'd3)
      word = (kern_q == 2'd2) ? {16'h0, word[7:0], word[15:8]}
                              : {word[7:0], word[15:8], word[23:16], word[31:24]};
  end

  assign nxt  = step(crc_q, word, kern_q);
  assign post = (ro_q ? (rev32(crc_q) >> (32 - kw(kern_q))) : crc_q)
              ^ (xo_q ? kmask(kern_q) : 32'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kern_q <= 2'd0;
      ri_q   <= 1'b1;
      ro_q   <= 1'b1;
      xo_q   <= 1'b1;
      sw_q   <= 1'b0;
      crc_q  <= 32'hFFFF_FFFF;
      res_q  <= 32'h0;
    end else begin
      res_q <= post;
      if (cfg_wr) begin
        kern_q <= cfg_kern;
        ri_q   <= cfg_std ? (cfg_kern[1] == 1'b0) : cfg_refl_in;
        ro_q   <= cfg_std ? (cfg_kern[1] == 1'b0) : cfg_refl_out;
        xo_q   <= cfg_std ? (cfg_kern != 2'd2)    : cfg_xor;
        sw_q   <= cfg_std ? 1'b0 : cfg_swap;
        crc_q  <= kmask(cfg_kern);
      end else if (init_load) begin
        crc_q <= kmask(kern_q);
      end else if (din_valid) begin
        crc_q <= nxt;
      end
    end
  end

  assign crc_out = crc_q;
  assign res_out = res_q;

endmodule

// File: rtl/crc_lane_chk.sv
module crc_lane_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [1:0]  cfg_kern,
  input logic        init_load,
  input logic        din_valid,
  input logic [1:0]  kern,
  input logic [2:0]  cfg_bits,
  input logic [31:0] crc_out,
  input logic [31:0] res_out
);

  function automatic logic [31:0] seed(input logic [1:0] k);
    return (k == 2'd3) ? 32'hFF : (k == 2'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !init_load && !din_valid) |=> $stable(crc_out));

  assert_cfg_seed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (crc_out == seed($past(cfg_kern))));

  assert_init_seed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (init_load && !cfg_wr) |=> (crc_out == seed(kern)));

  assert_crc_zext_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (kern == 2'd2) |-> (crc_out[31:16] == 16'h0));

  assert_res_zext_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (kern == 2'd3 && $past(kern) == 2'd3 && $past(rst_n)) |-> (res_out[31:8] == 24'h0));

  assert_res_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(crc_out) && $stable(kern) && $stable(cfg_bits))
      |=> $stable(res_out));

endmodule

bind crc_lane crc_lane_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_kern(cfg_kern),
  .init_load(init_load), .din_valid(din_valid), .kern(kern_q),
  .cfg_bits({ri_q, ro_q, xo_q}), .crc_out(crc_out), .res_out(res_out));

// File: tb/sim_crc_lane.sv
`timescale 1ns/1ps
module sim_crc_lane;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_std = 0, cfg_refl_in = 0, cfg_refl_out = 0, cfg_xor = 0, cfg_swap = 0;
  logic [1:0] cfg_kern = 0;
  logic init_load = 0, din_valid = 0;
  logic [31:0] din = 0, crc_out, res_out;

  int n_run = 0, n_fail = 0;
  logic [1:0] ek;
  logic eri, ero, exo, esw;
  logic [31:0] ecrc;

  always #2.5 clk = ~clk;

  crc_lane u0 (.*);

  function automatic int m_w(input logic [1:0] k);
    return k == 3 ? 8 : k == 2 ? 16 : 32;
  endfunction
  function automatic logic [31:0] m_mask(input logic [1:0] k);
    return k == 3 ? 32'hFF : k == 2 ? 32'hFFFF : 32'hFFFFFFFF;
  endfunction
  function automatic logic [31:0] m_poly(input logic [1:0] k);
    return k == 0 ? 32'h04C11DB7 : k == 1 ? 32'hF4ACFB13 : k == 2 ? 32'h1021 : 32'h1D;
  endfunction
  function automatic logic [31:0] m_pre(input logic [31:0] d, input logic [1:0] k,
                                        input logic ri, input logic sw);
    logic [31:0] v, r;
    v = d & m_mask(k);
    if (ri) begin
      r = 0;
      for (int b = 0; b < 4; b++)
        for (int j = 0; j < 8; j++) r[b*8 + j] = v[b*8 + 7 - j];
      v = r;
    end
    if (sw && m_w(k) == 32) v = {v[7:0], v[15:8], v[23:16], v[31:24]};
    if (sw && m_w(k) == 16) v = {16'h0, v[7:0], v[15:8]};
    return v;
  endfunction
  function automatic logic [31:0] m_crc(input logic [31:0] c, input logic [31:0] d,
                                        input logic [1:0] k);
    logic fb;
    int w;
    w = m_w(k);
    for (int i = 31; i >= 0; i--)
      if (i < w) begin
        fb = c[w-1] ^ d[i];
        c  = (c << 1) & m_mask(k);
        if (fb) c = c ^ m_poly(k);
      end
    return c;
  endfunction
  function automatic logic [31:0] m_post(input logic [31:0] c, input logic [1:0] k,
                                         input logic ro, input logic xo);
    logic [31:0] r;
    int w;
    w = m_w(k);
    r = c;
    if (ro) begin
      r = 0;
      for (int i = 0; i < 32; i++) if (i < w) r[w-1-i] = c[i];
    end
    if (xo) r = r ^ m_mask(k);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_cfg(input logic [1:0] k, input logic std, input logic ri,
                        input logic ro, input logic xo, input logic sw, input string tag);
    cfg_wr = 1; cfg_std = std; cfg_kern = k;
    cfg_refl_in = ri; cfg_refl_out = ro; cfg_xor = xo; cfg_swap = sw;
    @(negedge clk);
    cfg_wr = 0;
    ek = k;
    eri = std ? (k < 2) : ri;
    ero = std ? (k < 2) : ro;
    exo = std ? (k != 2) : xo;
    esw = std ? 1'b0 : sw;
    ecrc = m_mask(k);
    check(tag, crc_out, ecrc);
  endtask

  task automatic do_write(input logic [31:0] d, input string tag);
    din_valid = 1; din = d;
    @(negedge clk);
    din_valid = 0;
    ecrc = m_crc(ecrc, m_pre(d, ek, eri, esw), ek);
    check({tag, " crc"}, crc_out, ecrc);
    @(negedge clk);
    check({tag, " res"}, res_out, m_post(ecrc, ek, ero, exo));
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] c1, hold;
    ek = 0; eri = 1; ero = 1; exo = 1; esw = 0; ecrc = 32'hFFFFFFFF;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R8 reset res", res_out, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset crc", crc_out, 32'hFFFFFFFF);
    do_write(32'h12345678, "R8 default flags");

    do_cfg(2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R9 std k3 seed");
    for (int i = 0; i < 9; i++) do_write(32'h31 + i, "R1 k3 digits");
    check("R1 k3 check value", res_out, 32'h4B);

    do_cfg(2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R9 std k2 seed");
    do_write(32'hABCD_1234, "R9 std ignores switches");
    check("R2 upper ignored", crc_out, m_crc(32'hFFFF, 32'h1234, 2'd2));
    check("R11 k2 zext crc", crc_out & 32'hFFFF0000, 32'h0);

    do_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 k3 custom");
    do_write(32'h0000_00A5, "R4 swap no effect k3");
    check("R4 k3 swap ignored", crc_out, m_crc(32'hFF, 32'hA5, 2'd3));
    check("R11 k3 zext res", res_out & 32'hFFFFFF00, 32'h0);

    do_cfg(2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R9 k0 custom");
    do_write(32'h0102_0304, "R3 R4 R5 R6 k0");
    hold = crc_out;
    repeat (4) @(negedge clk);
    check("R12 idle hold", crc_out, hold);

    din = 32'hDEADBEEF; din_valid = 1;
    @(negedge clk);
    c1 = m_crc(ecrc, m_pre(32'hDEADBEEF, ek, eri, esw), ek);
    check("R7 b2b first crc", crc_out, c1);
    din = 32'h0BADF00D;
    @(negedge clk);
    din_valid = 0;
    ecrc = m_crc(c1, m_pre(32'h0BADF00D, ek, eri, esw), ek);
    check("R7 b2b second crc", crc_out, ecrc);
    check("R7 b2b res lags", res_out, m_post(c1, ek, ero, exo));
    @(negedge clk);
    check("R7 b2b res final", res_out, m_post(ecrc, ek, ero, exo));

    init_load = 1; din_valid = 1; din = 32'h55;
    @(negedge clk);
    init_load = 0; din_valid = 0;
    ecrc = m_mask(ek);
    check("R10 init over write", crc_out, ecrc);

    init_load = 1; din_valid = 1;
    do_cfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 cfg over init");
    init_load = 0; din_valid = 0;
    @(negedge clk);

    for (int t = 0; t < 40; t++) begin
      logic [3:0] f;
      logic [1:0] k;
      f = 4'($urandom);
      k = 2'($urandom);
      do_cfg(k, 1'b0, f[0], f[1], f[2], f[3], "R9 random cfg");
      for (int n = 0; n < 1 + int'($urandom % 6); n++)
        do_write($urandom, "R1 R3 R4 R5 R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule